// File: doc/BRIEF.md
# Embedded Controller Host Port

This block is the device side of a byte-wide host window into a 256-byte internal register space. The host sees two ports, picked by one select bit. Select 0 is the data port. Select 1 returns a status byte when read and takes a command byte when written. The host never addresses an internal register directly. It issues a command byte and then feeds address and data bytes one at a time. Before each byte it polls the status byte for the input-buffer-full flag (IBF) to clear. Before it takes a result from the data port, it polls for the output-buffer-full flag (OBF) to set.

Inside, a sequencer consumes each host byte a fixed number of cycles after it lands. It walks a read or a write transaction and drives a plain address/data port into the register space. That port has a one-cycle read latency. A read places the addressed value in the data port and raises OBF. A write issues a single write strobe. The sequencer has five named states:

- IDLE: nothing in progress.
- RD_ADDR: a read command has arrived and the address byte is awaited.
- RD_LOAD: the fetched value is being captured into the data port.
- WR_ADDR: a write command has arrived and the address byte is awaited.
- WR_DATA: the address is held and the data byte is awaited.

The transitions are as follows:

- A consumed command byte 0x80 goes to RD_ADDR from any state.
- A consumed command byte 0x81 goes to WR_ADDR from any state.
- Any other consumed command byte goes to IDLE.
- An address byte goes from RD_ADDR to RD_LOAD.
- RD_LOAD always returns to IDLE.
- An address byte goes from WR_ADDR to WR_DATA.
- A data byte goes from WR_DATA to IDLE.

Top module: `ec_host_port`

## Requirements
- R1: After reset IBF and OBF are 0, the status byte reads 0x00, and neither register strobe (write or read) is asserted.
- R2: Reading with select 1 returns a status byte with IBF in bit 1, OBF in bit 0, and the other bits zero. Reading with select 0 returns the data-port byte.
- R3: A host write to either port, accepted while IBF is 0, sets IBF from the next cycle. IBF then stays set for exactly CONSUME_CYC cycles (default 2) and clears.
- R4: A host write arriving while IBF is set is discarded and has no effect on any later transaction.
- R5: Command 0x80 followed by an address byte produces one register read strobe at that address. The returned value then appears on the data port with OBF set.
- R6: A host read of the data port clears OBF. Reading the status byte leaves OBF unchanged.
- R7: Command 0x81, an address byte and a data byte produce exactly one register write strobe carrying that address and that data.
- R8: A command byte consumed in the middle of a transaction abandons the transaction with no register access and starts the new command.
- R9: A command byte other than 0x80 or 0x81 is consumed (IBF clears) and returns the sequencer to IDLE. Data bytes that follow cause no register access.
- R10: A data-port byte consumed in IDLE causes no register access and leaves OBF at 0.
- R11: When a result is loaded into the data port in the same cycle as a host read of the data port, the load wins: OBF stays set and the new value is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Port select: 0 data, 1 status/command |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wdata | input | DW | Byte written by the host |
| host_rdata | output | DW | Byte returned to the host for the selected port |
| reg_addr | output | DW | Internal register address |
| reg_wdata | output | DW | Internal register write data |
| reg_we | output | 1 | Internal register write strobe |
| reg_re | output | 1 | Internal register read strobe |
| reg_rdata | input | DW | Internal read data, valid the cycle after reg_re |

## Verification
A result can be loaded into the data port in the same cycle as a host read of that port: the load sets OBF while the read clears it. The bench provokes this by counting cycles from the edge that captures a read address. It asserts the host read strobe exactly in the RD_LOAD cycle. It then judges that OBF is still set and that the following read returns the freshly fetched register value. A second overlap is a host write arriving while IBF is still set. The bench judges this by checking that the extra byte leaves no trace on the register transaction that follows.

// File: rtl/ec_host_pkg.sv
package ec_host_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ADDR,
        ST_RD_LOAD,
        ST_WR_ADDR,
        ST_WR_DATA
    } seq_state_t;

    localparam logic [7:0] CMD_READ  = 8'h80;
    localparam logic [7:0] CMD_WRITE = 8'h81;

    localparam int STS_OBF_BIT = 0;
    localparam int STS_IBF_BIT = 1;

endpackage

// File: rtl/ec_inbuf.sv
module ec_inbuf #(
    parameter int DW          = 8,
    parameter int CONSUME_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic          ibf,
    output logic          take,
    output logic [DW-1:0] byte_q,
    output logic          is_cmd_q
);
    localparam int CW = $clog2(CONSUME_CYC + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(CONSUME_CYC);
    localparam logic [CW-1:0] CNT_LAST = CW'(1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ibf      <= 1'b0;
            cnt      <= '0;
            byte_q   <= '0;
            is_cmd_q <= 1'b0;
        end else if (wr_en && !ibf) begin
            ibf      <= 1'b1;
            cnt      <= CNT_LOAD;
            byte_q   <= wr_data;
            is_cmd_q <= wr_sel;
        end else if (ibf) begin
            if (cnt == CNT_LAST) ibf <= 1'b0;
            cnt <= cnt - CNT_LAST;
        end
    end

    assign take = ibf && (cnt == CNT_LAST);

    AST_IBF_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ibf) |-> $past(wr_en)); // R3
    AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (ibf && wr_en) |=> ($stable(byte_q) && $stable(is_cmd_q))); // R4
    AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take); // R3

endmodule

// File: rtl/ec_outbuf.sv
module ec_outbuf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          host_take,
    output logic          obf,
    output logic [DW-1:0] data_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            obf    <= 1'b0;
            data_q <= '0;
        end else if (load) begin
            obf    <= 1'b1;
            data_q <= load_data;
        end else if (host_take) begin
            obf    <= 1'b0;
        end
    end

    AST_OBF_FALL_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(obf) |-> $past(host_take)); // R6
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (obf && data_q == $past(load_data))); // R11

endmodule

// File: rtl/ec_seq.sv
module ec_seq
    import ec_host_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          is_cmd,
    input  logic [DW-1:0] byte_in,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    output logic          reg_re,
    output logic          ob_load,
    output logic [DW-1:0] ob_data
);
    localparam logic [DW-1:0] C_RD = DW'(CMD_READ);
    localparam logic [DW-1:0] C_WR = DW'(CMD_WRITE);

    seq_state_t state, nxt;
    logic [DW-1:0] addr_q;
    logic          got_cmd, got_data;

    assign got_cmd  = take && is_cmd;
    assign got_data = take && !is_cmd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
        end else begin
            state <= nxt;
            if (state == ST_WR_ADDR && got_data) addr_q <= byte_in;
        end
    end

    always_comb begin
        nxt = state;
        if (got_cmd) begin
            if (byte_in == C_RD)      nxt = ST_RD_ADDR;
            else if (byte_in == C_WR) nxt = ST_WR_ADDR;
            else                      nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    nxt = ST_IDLE;
                ST_RD_ADDR: if (got_data) nxt = ST_RD_LOAD;
                ST_RD_LOAD: nxt = ST_IDLE;
                ST_WR_ADDR: if (got_data) nxt = ST_WR_DATA;
                ST_WR_DATA: if (got_data) nxt = ST_IDLE;
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        reg_addr  = '0;
        reg_wdata = '0;
        reg_we    = 1'b0;
        reg_re    = 1'b0;
        ob_load   = 1'b0;
        ob_data   = mem_rdata;
        unique case (state)
            ST_IDLE: ;
            ST_RD_ADDR: if (got_data) begin
                reg_re   = 1'b1;
                reg_addr = byte_in;
            end
            ST_RD_LOAD: ob_load = 1'b1;
            ST_WR_ADDR: ;
            ST_WR_DATA: if (got_data) begin
                reg_we    = 1'b1;
                reg_addr  = addr_q;
                reg_wdata = byte_in;
            end
            default: ;
        endcase
    end

    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we, reg_re, ob_load})); // R7
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we); // R7
    AST_RE_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> ob_load); // R5
    AST_CMD_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        got_cmd |-> (!reg_we && !reg_re)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!reg_we && !reg_re)); // R10

endmodule

// File: rtl/ec_host_port.sv
module ec_host_port
    import ec_host_pkg::*;
#(
    parameter int DW          = 8,
    parameter int CONSUME_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_sel,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic [DW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    output logic          reg_re,
    input  logic [DW-1:0] reg_rdata
);
    logic          ibf, obf, take, is_cmd, ob_load, host_take;
    logic [DW-1:0] in_byte, ob_data, ob_q, status;

    assign host_take = host_rd && !host_sel;

    ec_inbuf #(.DW(DW), .CONSUME_CYC(CONSUME_CYC)) u_in (
        .clk(clk), .rst_n(rst_n), .wr_en(host_wr), .wr_sel(host_sel),
        .wr_data(host_wdata), .ibf(ibf), .take(take),
        .byte_q(in_byte), .is_cmd_q(is_cmd)
    );

    ec_seq #(.DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .take(take), .is_cmd(is_cmd),
        .byte_in(in_byte), .mem_rdata(reg_rdata), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
        .ob_load(ob_load), .ob_data(ob_data)
    );

    ec_outbuf #(.DW(DW)) u_out (
        .clk(clk), .rst_n(rst_n), .load(ob_load), .load_data(ob_data),
        .host_take(host_take), .obf(obf), .data_q(ob_q)
    );

    always_comb begin
        status              = '0;
        status[STS_IBF_BIT] = ibf;
        status[STS_OBF_BIT] = obf;
    end

    assign host_rdata = host_sel ? status : ob_q;

    AST_STATUS_READ_KEEPS_OBF: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_sel && obf) |=> obf); // R6

endmodule

// File: tb/ec_host_port_test.sv
`timescale 1ns/1ps
module ec_host_port_test;
    localparam int DW = 8;
    localparam int CC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_sel = 1'b1, host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata, reg_addr, reg_wdata, reg_rdata;
    logic reg_we, reg_re;

    int tests = 0, fails = 0, n_we = 0, n_re = 0;
    logic [7:0] ram [256];
    logic [7:0] expm [256];

    always #2 clk = ~clk;

    ec_host_port #(.DW(DW), .CONSUME_CYC(CC)) uut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    always @(posedge clk) begin
        if (reg_we) begin ram[reg_addr] <= reg_wdata; n_we <= n_we + 1; end
        if (reg_re) begin reg_rdata <= ram[reg_addr]; n_re <= n_re + 1; end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic status_now(output logic [7:0] s);
        host_sel = 1'b1; #1; s = host_rdata;
    endtask

    task automatic h_wr(input logic sel, input logic [7:0] d);
        logic [7:0] s;
        @(negedge clk); status_now(s);
        while (s[1]) begin @(negedge clk); status_now(s); end
        host_sel = sel; host_wdata = d; host_wr = 1'b1;
        @(negedge clk); host_wr = 1'b0; host_sel = 1'b1;
    endtask

    task automatic h_rd(output logic [7:0] v);
        logic [7:0] s;
        @(negedge clk); status_now(s);
        while (!s[0]) begin @(negedge clk); status_now(s); end
        host_sel = 1'b0; host_rd = 1'b1; #1; v = host_rdata;
        @(negedge clk); host_rd = 1'b0; host_sel = 1'b1;
    endtask

    task automatic settle();
        repeat (CC + 4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] s, v;
        int we0, re0;
        for (int i = 0; i < 256; i++) begin ram[i] = 8'h00; expm[i] = 8'h00; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); status_now(s);
        chk(s == 8'h00, "R1 status after reset", s, 0);
        chk(!reg_we && !reg_re, "R1 strobes idle", {reg_we, reg_re}, 0);

        // R3 / R10: one data byte in IDLE; IBF visible for CC cycles
        host_sel = 1'b0; host_wdata = 8'h3C; host_wr = 1'b1;
        @(negedge clk); host_wr = 1'b0;
        for (int i = 0; i < CC; i++) begin
            status_now(s);
            chk(s == 8'h02, "R3 IBF held (R2 bit 1)", s, 2);
            @(negedge clk);
        end
        status_now(s);
        chk(s == 8'h00, "R3 IBF cleared", s, 0);
        settle();
        chk(n_we == 0 && n_re == 0, "R10 no access from idle data byte", n_we + n_re, 0);
        status_now(s);
        chk(s[0] == 1'b0, "R10 OBF stays clear", s, 0);

        // Sweep: write every register, then read every register back
        for (int a = 0; a < 256; a++) begin
            logic [7:0] d;
            d = 8'((a * 37 + 5) & 255);
            h_wr(1'b1, 8'h81); h_wr(1'b0, 8'(a)); h_wr(1'b0, d);
            expm[a] = d;
        end
        settle();
        chk(n_we == 256, "R7 one write strobe per transaction", n_we, 256);
        for (int a = 0; a < 256; a++) begin
            h_wr(1'b1, 8'h80); h_wr(1'b0, 8'(a)); h_rd(v);
            chk(v == expm[a], "R5 read returns register (R2 data port)", v, expm[a]);
        end
        chk(n_re == 256, "R5 one read strobe per transaction", n_re, 256);
        @(negedge clk); status_now(s);
        chk(s[0] == 1'b0, "R6 data read clears OBF", s, 0);

        // R6: status read keeps OBF
        h_wr(1'b1, 8'h80); h_wr(1'b0, 8'h07); settle();
        host_sel = 1'b1; host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
        status_now(s);
        chk(s[0] == 1'b1, "R6 status read keeps OBF", s, 1);
        h_rd(v);
        chk(v == expm[7], "R6 value after status read", v, expm[7]);

        // R4: command written while IBF busy is dropped
        we0 = n_we;
        h_wr(1'b1, 8'h81);
        host_sel = 1'b1; host_wdata = 8'h80; host_wr = 1'b1;
        @(negedge clk); host_wr = 1'b0;
        h_wr(1'b0, 8'h33); h_wr(1'b0, 8'hA5); expm[8'h33] = 8'hA5; settle();
        chk(n_we == we0 + 1, "R4 busy write dropped, write went through", n_we - we0, 1);
        h_wr(1'b1, 8'h80); h_wr(1'b0, 8'h33); h_rd(v);
        chk(v == 8'hA5, "R4 register value", v, 8'hA5);

        // R8: abort a write with a read command
        we0 = n_we; re0 = n_re;
        h_wr(1'b1, 8'h81); h_wr(1'b0, 8'h10);
        h_wr(1'b1, 8'h80); h_wr(1'b0, 8'h20); h_rd(v);
        chk(n_we == we0, "R8 aborted write makes no access", n_we - we0, 0);
        chk(v == expm[8'h20] && n_re == re0 + 1, "R8 new command runs", v, expm[8'h20]);

        // R9: unknown command, then stray bytes
        we0 = n_we; re0 = n_re;
        h_wr(1'b1, 8'h81); h_wr(1'b1, 8'h55);
        status_now(s); settle(); status_now(s);
        chk(s[1] == 1'b0, "R9 unknown command consumed", s, 0);
        h_wr(1'b0, 8'h44); h_wr(1'b0, 8'h99); settle();
        chk(n_we == we0 && n_re == re0, "R9 no access after unknown command", n_we + n_re - we0 - re0, 0);

        // R11: host read of data port in the load cycle
        h_wr(1'b1, 8'h80);
        h_wr(1'b0, 8'h42);
        @(negedge clk);
        @(negedge clk); host_sel = 1'b0; host_rd = 1'b1;
        @(negedge clk); host_rd = 1'b0; host_sel = 1'b1;
        status_now(s);
        chk(s[0] == 1'b1, "R11 load wins over read", s, 1);
        h_rd(v);
        chk(v == expm[8'h42], "R11 new value kept", v, expm[8'h42]);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule